// File: doc/BRIEF.md
# Multi-Channel Consecutive Alert Filter

This block sits behind a temperature conversion engine and decides when a channel's readings have been out of range long enough to raise an alarm. For each conversion it receives one signed result per channel, plus a diode-fault flag per channel. It compares each result against that channel's high and low limits and keeps a separate run-length counter of back-to-back violations for each channel. When a counter reaches the programmed run length, the block drives an active-low alert line and records per-channel status. Per-channel mask bits keep a channel off the alert line but leave its counter and status working.

A single mode input selects between two behaviours. In interrupt mode, status bits and the alert line are sticky until a status-read strobe clears them. In comparator mode, only high-limit violations count, and the alert line tracks a per-channel trip condition with release hysteresis. A two-state controller frames each conversion. In ST_IDLE, a `conv_start` pulse latches the limits, the hysteresis and the run-length code, and the controller moves to ST_CONV (transition START). In ST_CONV, a `res_valid` pulse applies the results to every channel and returns the controller to ST_IDLE (transition FINISH). Any other input leaves the state where it is (transition HOLD).

Top module: `temp_alert_filter`

## Requirements
- R1: A result violates the high limit when it is strictly greater than the latched high limit, and violates the low limit when it is less than or equal to the latched low limit. Both comparisons are signed.
- R2: The run-length code on `cnt_code_i` sets the required number of consecutive violating conversions to one plus the number of ones in the code: 000 gives 1, 001 gives 2, 011 gives 3 and 111 gives 4. After reset the required count is 1.
- R3: Each channel has its own counter. A conversion with no violation on a channel clears that channel's counter, and it changes no other channel's counter. A counter changes only when results are applied.
- R4: In interrupt mode, a channel whose counter reaches the required count on a conversion does three things. It sets its high status bit if the result is above the high limit, or its low status bit if the result is at or below the low limit. It asserts `alert_n_o` low. It resets its counter to 0. The other channels' counters keep their values.
- R5: In interrupt mode, a set fault flag takes precedence over the result. It sets that channel's fault status bit, asserts `alert_n_o` and clears that channel's counter.
- R6: In interrupt mode, the status bits and the alert line stay set until a `stat_clr_i` pulse. A set event in the same cycle as the clear pulse wins.
- R7: In comparator mode, low-limit violations and fault flags are ignored. They change no counter and set no low or fault status bit. Only high-limit violations increment a counter.
- R8: In comparator mode, a channel trips when its counter reaches the required count. The counter is then held, and the channel's bit on `hi_stat_o` shows the trip. A tripped channel releases only on a result strictly less than the high limit minus the hysteresis, which clears its counter. `alert_n_o` is low while any unmasked channel is tripped.
- R9: A masked channel (`mask_i` bit 1) still updates its counter and status, but never drives `alert_n_o` low, in either mode.
- R10: Limits, hysteresis and the run-length code are captured only by `conv_start` in ST_IDLE. A change made while a conversion is running takes effect at the next conversion.
- R11: `res_valid` has no effect in ST_IDLE, and `conv_start` has no effect in ST_CONV.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_start | input | 1 | Conversion start pulse; latches limits and code |
| res_valid | input | 1 | Results valid pulse; applies results to every channel |
| res_i | input | CH*TW | Signed result per channel; channel i in bits [i*TW +: TW] |
| fault_i | input | CH | Diode fault flag per channel |
| hi_lim_i | input | CH*TW | Signed high limit per channel |
| lo_lim_i | input | CH*TW | Signed low limit per channel |
| hyst_i | input | TW | Unsigned release hysteresis for comparator mode |
| cnt_code_i | input | 3 | Run-length code |
| comp_mode_i | input | 1 | 1 = comparator mode, 0 = interrupt mode |
| mask_i | input | CH | Per-channel alert mask |
| stat_clr_i | input | 1 | Status-read strobe; clears sticky status and alert |
| alert_n_o | output | 1 | Active-low alert |
| hi_stat_o | output | CH | High status (sticky in interrupt mode, trip level in comparator mode) |
| lo_stat_o | output | CH | Low status per channel |
| flt_stat_o | output | CH | Fault status per channel |

## Verification
The bench builds the block with three channels and 8-bit signed results. Three channels are enough to show counters advancing independently and to replay a five-conversion sequence in which only the middle channel fires, with a run length of 4 and a high limit of 70. The 8-bit width keeps limits such as 70 and -20, and the values on either side of them, easy to read. A behavioural reference model is compared with the block on every clock. Directed checks cover the limit boundaries, fault precedence, a clear pulse that lands on a set event, masking in both modes, a limit changed in mid-conversion, and the hysteresis band in comparator mode.

// File: rtl/taf_pkg.sv
package taf_pkg;
    localparam int CNT_W = 3;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_CONV = 1'b1
    } taf_state_t;

    // required run length: one plus the ones in the code
    function automatic logic [CNT_W-1:0] code_to_need(input logic [2:0] code);
        return CNT_W'(3'd1 + {2'b00, code[0]} + {2'b00, code[1]} + {2'b00, code[2]});
    endfunction
endpackage

// File: rtl/taf_limit_latch.sv
module taf_limit_latch
    import taf_pkg::*;
#(
    parameter int CH = 3,
    parameter int TW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [CH*TW-1:0]     hi_in,
    input  logic [CH*TW-1:0]     lo_in,
    input  logic [TW-1:0]        hyst_in,
    input  logic [2:0]           code_in,
    output logic [CH*TW-1:0]     hi_q,
    output logic [CH*TW-1:0]     lo_q,
    output logic [TW-1:0]        hyst_q,
    output logic [CNT_W-1:0]     need_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q   <= '0;
            lo_q   <= '0;
            hyst_q <= '0;
            need_q <= CNT_W'(1);
        end else if (load) begin
            hi_q   <= hi_in;
            lo_q   <= lo_in;
            hyst_q <= hyst_in;
            need_q <= code_to_need(code_in);
        end
    end

    // R2
    need_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (need_q >= CNT_W'(1)) && (need_q <= CNT_W'(4)));
endmodule

// File: rtl/taf_chan.sv
module taf_chan
    import taf_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  upd,
    input  logic                  clr,
    input  logic                  comp_mode,
    input  logic [CNT_W-1:0]      need,
    input  logic signed [TW-1:0]  res,
    input  logic signed [TW-1:0]  hi,
    input  logic signed [TW-1:0]  lo,
    input  logic [TW-1:0]         hyst,
    input  logic                  fault,
    output logic                  hi_st,
    output logic                  lo_st,
    output logic                  flt_st,
    output logic                  trip,
    output logic                  raise
);
    localparam int EW = TW + 2;

    logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
    logic             hi_lat, lo_lat, flt_lat;
    logic             hi_set, lo_set, flt_set;
    logic             hi_v, lo_v, rel;
    logic signed [EW-1:0] res_x, hi_x, floor_x;

    assign hi_v    = res > hi;
    assign lo_v    = res <= lo;
    assign res_x   = $signed({{2{res[TW-1]}}, res});
    assign hi_x    = $signed({{2{hi[TW-1]}}, hi});
    assign floor_x = hi_x - $signed({2'b00, hyst});
    assign rel     = res_x < floor_x;
    assign cnt_inc = cnt_q + CNT_W'(1);
    assign trip    = cnt_q >= need;

    always_comb begin
        cnt_d   = cnt_q;
        hi_set  = 1'b0;
        lo_set  = 1'b0;
        flt_set = 1'b0;
        if (upd) begin
            if (comp_mode) begin
                if (trip) begin
                    cnt_d = rel ? '0 : cnt_q;
                end else if (hi_v) begin
                    cnt_d = cnt_inc;
                end else begin
                    cnt_d = '0;
                end
            end else begin
                if (fault) begin
                    cnt_d   = '0;
                    flt_set = 1'b1;
                end else if (hi_v || lo_v) begin
                    if (cnt_inc >= need) begin
                        cnt_d  = '0;
                        hi_set = hi_v;
                        lo_set = lo_v;
                    end else begin
                        cnt_d = cnt_inc;
                    end
                end else begin
                    cnt_d = '0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            hi_lat  <= 1'b0;
            lo_lat  <= 1'b0;
            flt_lat <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            if (hi_set)   hi_lat  <= 1'b1;
            else if (clr) hi_lat  <= 1'b0;
            if (lo_set)   lo_lat  <= 1'b1;
            else if (clr) lo_lat  <= 1'b0;
            if (flt_set)  flt_lat <= 1'b1;
            else if (clr) flt_lat <= 1'b0;
        end
    end

    assign raise  = hi_set | lo_set | flt_set;
    assign hi_st  = comp_mode ? trip : hi_lat;
    assign lo_st  = lo_lat;
    assign flt_st = flt_lat;

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(4));
    // R3
    cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(cnt_q));
    // R5
    fault_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !comp_mode && fault) |=> (flt_lat && cnt_q == '0));
    // R7
    comp_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && comp_mode && !clr) |=> ($stable(lo_lat) && $stable(flt_lat)));
endmodule

// File: rtl/temp_alert_filter.sv
module temp_alert_filter
    import taf_pkg::*;
#(
    parameter int CH = 3,
    parameter int TW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_start,
    input  logic              res_valid,
    input  logic [CH*TW-1:0]  res_i,
    input  logic [CH-1:0]     fault_i,
    input  logic [CH*TW-1:0]  hi_lim_i,
    input  logic [CH*TW-1:0]  lo_lim_i,
    input  logic [TW-1:0]     hyst_i,
    input  logic [2:0]        cnt_code_i,
    input  logic              comp_mode_i,
    input  logic [CH-1:0]     mask_i,
    input  logic              stat_clr_i,
    output logic              alert_n_o,
    output logic [CH-1:0]     hi_stat_o,
    output logic [CH-1:0]     lo_stat_o,
    output logic [CH-1:0]     flt_stat_o
);
    taf_state_t state_q, state_d;
    logic       load, upd;
    logic       int_alert;

    logic [CH*TW-1:0] hi_q, lo_q;
    logic [TW-1:0]    hyst_q;
    logic [CNT_W-1:0] need_q;
    logic [CH-1:0]    trip, raise;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and per-state strobes
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        upd     = 1'b0;
        unique case (state_q)
            ST_IDLE: if (conv_start) begin
                load    = 1'b1;
                state_d = ST_CONV;
            end
            ST_CONV: if (res_valid) begin
                upd     = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    taf_limit_latch #(.CH(CH), .TW(TW)) latch_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .hi_in   (hi_lim_i),
        .lo_in   (lo_lim_i),
        .hyst_in (hyst_i),
        .code_in (cnt_code_i),
        .hi_q    (hi_q),
        .lo_q    (lo_q),
        .hyst_q  (hyst_q),
        .need_q  (need_q)
    );

    for (genvar g = 0; g < CH; g++) begin : g_chan
        taf_chan #(.TW(TW)) chan_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .upd       (upd),
            .clr       (stat_clr_i),
            .comp_mode (comp_mode_i),
            .need      (need_q),
            .res       (res_i[g*TW +: TW]),
            .hi        (hi_q[g*TW +: TW]),
            .lo        (lo_q[g*TW +: TW]),
            .hyst      (hyst_q),
            .fault     (fault_i[g]),
            .hi_st     (hi_stat_o[g]),
            .lo_st     (lo_stat_o[g]),
            .flt_st    (flt_stat_o[g]),
            .trip      (trip[g]),
            .raise     (raise[g])
        );
    end

    // sticky interrupt-mode alert
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      int_alert <= 1'b0;
        else if (|(raise & ~mask_i))     int_alert <= 1'b1;
        else if (stat_clr_i)             int_alert <= 1'b0;
    end

    assign alert_n_o = comp_mode_i ? ~|(trip & ~mask_i) : ~int_alert;

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !conv_start) |=> state_q == ST_IDLE);
    // R10
    limit_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONV) |=> ($stable(hi_q) && $stable(lo_q) && $stable(need_q)));
    // R6
    alert_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_alert && !stat_clr_i) |=> int_alert);
    // R9
    mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (comp_mode_i && ((trip & ~mask_i) == '0)) |-> alert_n_o);
endmodule

// File: tb/temp_alert_filter_tb.sv
module temp_alert_filter_tb_top;
    localparam int CH = 3;
    localparam int TW = 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, conv_start, res_valid, stat_clr, comp_mode;
    logic [2:0] code;
    logic [CH-1:0] mask, fault;
    logic [TW-1:0] hyst;
    logic signed [TW-1:0] res_a [CH];
    logic signed [TW-1:0] hi_a  [CH];
    logic signed [TW-1:0] lo_a  [CH];
    logic [CH*TW-1:0] res_bus, hi_bus, lo_bus;
    logic alert_n;
    logic [CH-1:0] hi_stat, lo_stat, flt_stat;

    always_comb begin
        for (int i = 0; i < CH; i++) begin
            res_bus[i*TW +: TW] = res_a[i];
            hi_bus[i*TW +: TW]  = hi_a[i];
            lo_bus[i*TW +: TW]  = lo_a[i];
        end
    end

    temp_alert_filter #(.CH(CH), .TW(TW)) dut_i (
        .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .res_valid(res_valid),
        .res_i(res_bus), .fault_i(fault), .hi_lim_i(hi_bus), .lo_lim_i(lo_bus),
        .hyst_i(hyst), .cnt_code_i(code), .comp_mode_i(comp_mode), .mask_i(mask),
        .stat_clr_i(stat_clr), .alert_n_o(alert_n), .hi_stat_o(hi_stat),
        .lo_stat_o(lo_stat), .flt_stat_o(flt_stat)
    );

    int nvec = 0, nfail = 0;
    bit done = 0;

    // behavioural reference model
    int m_cnt [CH];
    bit m_hs [CH], m_ls [CH], m_fs [CH];
    bit m_ia, m_conv;
    int l_hi [CH], l_lo [CH], l_hy, l_need;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < CH; i++) begin
                m_cnt[i] = 0; m_hs[i] = 0; m_ls[i] = 0; m_fs[i] = 0;
                l_hi[i] = 0; l_lo[i] = 0;
            end
            m_ia = 0; m_conv = 0; l_hy = 0; l_need = 1;
        end else begin
            if (stat_clr) begin
                m_ia = 0;
                for (int i = 0; i < CH; i++) begin m_hs[i] = 0; m_ls[i] = 0; m_fs[i] = 0; end
            end
            if (!m_conv && conv_start) begin
                for (int i = 0; i < CH; i++) begin l_hi[i] = hi_a[i]; l_lo[i] = lo_a[i]; end
                l_hy = hyst;
                l_need = 1 + code[0] + code[1] + code[2];
                m_conv = 1;
            end else if (m_conv && res_valid) begin
                for (int i = 0; i < CH; i++) begin
                    int r;
                    r = res_a[i];
                    if (comp_mode) begin
                        if (m_cnt[i] >= l_need) begin
                            if (r < l_hi[i] - l_hy) m_cnt[i] = 0;
                        end else if (r > l_hi[i]) m_cnt[i]++;
                        else m_cnt[i] = 0;
                    end else if (fault[i]) begin
                        m_fs[i] = 1; m_cnt[i] = 0;
                        if (!mask[i]) m_ia = 1;
                    end else if (r > l_hi[i] || r <= l_lo[i]) begin
                        if (m_cnt[i] + 1 >= l_need) begin
                            if (r > l_hi[i]) m_hs[i] = 1;
                            if (r <= l_lo[i]) m_ls[i] = 1;
                            m_cnt[i] = 0;
                            if (!mask[i]) m_ia = 1;
                        end else m_cnt[i]++;
                    end else m_cnt[i] = 0;
                end
                m_conv = 0;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit ea; logic [CH-1:0] eh, el, ef;
            ea = 0;
            for (int i = 0; i < CH; i++) begin
                bit t;
                t = m_cnt[i] >= l_need;
                eh[i] = comp_mode ? t : m_hs[i];
                el[i] = m_ls[i];
                ef[i] = m_fs[i];
                if (comp_mode ? (t && !mask[i]) : 1'b0) ea = 1;
            end
            if (!comp_mode) ea = m_ia;
            chk("model alert R4 R6 R8", alert_n, !ea);
            chk("model hi_stat R1 R4 R8", hi_stat, eh);
            chk("model lo_stat R1 R7", lo_stat, el);
            chk("model flt_stat R5 R7", flt_stat, ef);
        end
    end

    task automatic conv(input int a, input int b, input int c,
                        input logic [CH-1:0] flt, input bit clr_same);
        @(negedge clk) conv_start = 1;
        @(negedge clk) conv_start = 0;
        res_a[0] = 8'(a); res_a[1] = 8'(b); res_a[2] = 8'(c);
        fault = flt; res_valid = 1; stat_clr = clr_same;
        @(negedge clk) res_valid = 0; stat_clr = 0; fault = 0;
    endtask

    task automatic clr_pulse();
        @(negedge clk) stat_clr = 1;
        @(negedge clk) stat_clr = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 0; conv_start = 0; res_valid = 0; stat_clr = 0; comp_mode = 0;
        code = 3'b111; mask = '0; fault = '0; hyst = '0;
        for (int i = 0; i < CH; i++) begin res_a[i] = 0; hi_a[i] = 70; lo_a[i] = -20; end
        repeat (3) @(negedge clk);
        chk("reset alert_n", alert_n, 1);
        chk("reset hi_stat", hi_stat, 0);
        rst_n = 1;

        // five-conversion replay, run length 4 (R2, R3, R4)
        conv(71, 69, 69, 3'b000, 0);
        conv(71, 71, 68, 3'b000, 0);
        conv(69, 71, 69, 3'b000, 0);
        conv(71, 71, 71, 3'b000, 0);
        chk("R3 no fire before run complete", alert_n, 1);
        conv(71, 71, 71, 3'b000, 0);
        chk("R4 only middle channel fires", hi_stat, 3'b010);
        chk("R2 code 111 needs four", alert_n, 0);
        clr_pulse();
        chk("R6 clear drops alert", alert_n, 1);
        chk("R6 clear drops status", hi_stat, 0);

        // limit boundaries with run length 1 (R1)
        code = 3'b000;
        conv(70, -19, 0, 3'b000, 0);
        chk("R1 equal to high is no violation", alert_n, 1);
        conv(71, -20, 0, 3'b000, 0);
        chk("R1 high strict", hi_stat, 3'b001);
        chk("R1 low inclusive", lo_stat, 3'b010);
        clr_pulse();

        // fault precedence (R5)
        conv(0, 0, 100, 3'b100, 0);
        chk("R5 fault status", flt_stat, 3'b100);
        chk("R5 fault beats high", hi_stat, 3'b000);
        chk("R5 fault alerts", alert_n, 0);
        clr_pulse();

        // set wins over simultaneous clear (R6)
        conv(71, 0, 0, 3'b000, 1);
        chk("R6 set beats clear", alert_n, 0);
        clr_pulse();

        // masked channel (R9)
        mask = 3'b001;
        conv(71, 0, 0, 3'b000, 0);
        chk("R9 masked status", hi_stat, 3'b001);
        chk("R9 masked no alert", alert_n, 1);
        mask = '0;
        clr_pulse();

        // limit change in mid-conversion (R10)
        @(negedge clk) conv_start = 1;
        @(negedge clk) conv_start = 0;
        hi_a[1] = 80; res_a[0] = 0; res_a[1] = 75; res_a[2] = 0; res_valid = 1;
        @(negedge clk) res_valid = 0;
        chk("R10 old limit used", hi_stat, 3'b010);
        clr_pulse();
        conv(0, 75, 0, 3'b000, 0);
        chk("R10 new limit next conversion", alert_n, 1);

        // results outside a conversion (R11)
        res_a[1] = 100;
        @(negedge clk) res_valid = 1;
        @(negedge clk) res_valid = 0;
        chk("R11 idle res_valid ignored", hi_stat, 3'b000);
        chk("R11 idle res_valid no alert", alert_n, 1);
        hi_a[1] = 70;

        // comparator mode, run length 2, hysteresis 5 (R7, R8, R2)
        comp_mode = 1; code = 3'b001; hyst = 8'd5;
        conv(71, -30, 0, 3'b010, 0);
        chk("R7 low and fault ignored", lo_stat | flt_stat, 0);
        chk("R7 one high not yet", alert_n, 1);
        conv(71, 0, 0, 3'b000, 0);
        chk("R8 trip after two", alert_n, 0);
        chk("R8 trip shown", hi_stat, 3'b001);
        conv(68, 0, 0, 3'b000, 0);
        chk("R8 held inside band", alert_n, 0);
        conv(65, 0, 0, 3'b000, 0);
        chk("R8 held at floor", alert_n, 0);
        conv(64, 0, 0, 3'b000, 0);
        chk("R8 released below floor", alert_n, 1);
        mask = 3'b001;
        conv(71, 0, 0, 3'b000, 0);
        conv(71, 0, 0, 3'b000, 0);
        chk("R9 masked trip shown", hi_stat, 3'b001);
        chk("R9 masked trip silent", alert_n, 1);

        @(negedge clk);
        finish_run();
    end
endmodule